// File: doc/BRIEF.md
# Combining Prefix-Sum Unit

This block is a central fetch-and-add engine shared by a group of processing clusters. Each cluster has its own point-to-point request port carrying a base-register index and an unsigned increment. In any cycle, all accepted requests that name the same base register are merged into one atomic batch. The batch reads the old value of that base and advances the base by the sum of the batch's increments. Each member cluster is given a distinct slot, equal to the old value plus the increments of the lower-numbered members.

The batch result goes out on a shared broadcast bus that every cluster watches. Each lane of the bus carries a strobe, the base index, the old base value, a membership mask and one offset per cluster. A cluster adds its own offset to the old value to find the start of its sub-range. Several distinct bases can be served in one cycle, one per lane, and a new set of batches can enter on every cycle.

The request side uses valid/ready. A cluster raises `req_valid` with its base index and increment, and the transfer happens on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is combinational from the current requests. A cluster that sees `req_ready` low must hold its request unchanged until it is accepted. The broadcast side has no back-pressure.

Top module: `psum_combiner`

## Requirements
- R1: After reset every base register reads 0, no broadcast lane is valid, and `req_ready` is high on every port that has no request pending.
- R2: A request accepted at a rising edge appears on the broadcast bus after the second rising edge that follows it, and a lane is valid only for a batch accepted two edges earlier.
- R3: All requests accepted in one cycle that name the same base form a single batch in one lane. Bit k of that lane's field in `bc_mask` (bit lane*N_CL+k) is set exactly when cluster k belongs to the batch.
- R4: In a batch, the offset for cluster k is the sum of the increments of the member clusters with an index below k, modulo 2^W. It sits at bits [(lane*N_CL+k)*W +: W] of `bc_offs`. Distinct nonzero members therefore get disjoint slots.
- R5: `bc_old` carries the base value from before the batch, and the base then advances by the batch total. A batch to the same base in the very next cycle observes the advanced value.
- R6: Distinct bases in one cycle take lanes in order of their lowest-numbered requesting cluster: lane 0 first, up to LANES lanes. No two valid lanes carry the same base.
- R7: A request whose base would need a lane beyond LANES sees `req_ready` low and is not accepted. Every other request sees `req_ready` high.
- R8: A request with a zero increment is accepted and reported like any other member, but it does not change the base.
- R9: Base values and offsets wrap modulo 2^W.
- R10: Increments are unsigned IW-bit values, zero-extended to W bits before they are added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_CL | Request present, one bit per cluster |
| req_base | input | N_CL*BW | Base-register index per cluster, BW bits each |
| req_inc | input | N_CL*IW | Unsigned increment per cluster |
| req_ready | output | N_CL | Request can be accepted this cycle |
| bc_valid | output | LANES | Broadcast lane carries a batch |
| bc_base | output | LANES*BW | Base index of each lane's batch |
| bc_old | output | LANES*W | Base value before each lane's batch |
| bc_mask | output | LANES*N_CL | Member clusters of each lane's batch |
| bc_offs | output | LANES*N_CL*W | Per-cluster offset within each lane's batch |

## Verification
The assertions check four things on every cycle:
- an accepted request always produces a broadcast two edges later, and nothing is broadcast otherwise;
- a refused request implies that every lane was filled;
- valid lanes never share a base;
- no cluster sits in two lanes at once.

The values themselves can only be shown by the bench's reference model: the old bases, the per-cluster offsets, the lane order, the atomic advance of a base between back-to-back batches, zero-increment reads and modular wrap.

// File: rtl/psum_pkg.sv
package psum_pkg;
  parameter int unsigned PS_CLUSTERS = 4;
  parameter int unsigned PS_BASES    = 8;
  parameter int unsigned PS_WIDTH    = 16;
  parameter int unsigned PS_INC_W    = 8;
  parameter int unsigned PS_LANES    = 2;
endpackage

// File: rtl/psum_lane_sel.sv
module psum_lane_sel #(
  parameter int unsigned N_CL  = 4,
  parameter int unsigned BW    = 3,
  parameter int unsigned LANES = 2
) (
  input  logic [N_CL-1:0]       req_valid,
  input  logic [N_CL*BW-1:0]    req_base,
  output logic [N_CL-1:0]       req_ready,
  output logic [LANES-1:0]      lane_v,
  output logic [LANES*BW-1:0]   lane_base,
  output logic [LANES*N_CL-1:0] lane_mask
);
  localparam int unsigned CW = $clog2(N_CL + 1);

  logic [BW-1:0] b    [N_CL];
  logic [CW-1:0] rank [N_CL];
  logic [CW-1:0] grp  [N_CL];
  logic [N_CL-1:0] lead;
  logic [CW-1:0] cnt;

  for (genvar i = 0; i < N_CL; i++) begin : g_unpack
    assign b[i] = req_base[i*BW +: BW];
  end

  // leaders are the lowest-index requester of each distinct base; rank = lane
  always_comb begin
    cnt = '0;
    for (int i = 0; i < N_CL; i++) begin
      lead[i] = req_valid[i];
      for (int j = 0; j < i; j++)
        if (req_valid[j] && b[j] == b[i]) lead[i] = 1'b0;
      rank[i] = cnt;
      if (lead[i]) cnt = cnt + CW'(1);
    end
    for (int i = 0; i < N_CL; i++) begin
      grp[i] = rank[i];
      for (int j = i - 1; j >= 0; j--)
        if (req_valid[j] && b[j] == b[i]) grp[i] = rank[j];
      req_ready[i] = !req_valid[i] || (grp[i] < CW'(LANES));
    end
    lane_v    = '0;
    lane_base = '0;
    lane_mask = '0;
    for (int l = 0; l < LANES; l++)
      for (int i = 0; i < N_CL; i++)
        if (req_valid[i] && grp[i] == CW'(l)) begin
          lane_v[l]                = 1'b1;
          lane_base[l*BW +: BW]    = b[i];
          lane_mask[l*N_CL + i]    = 1'b1;
        end
  end
endmodule

// File: rtl/psum_batch_exec.sv
module psum_batch_exec #(
  parameter int unsigned N_CL = 4,
  parameter int unsigned W    = 16,
  parameter int unsigned IW   = 8
) (
  input  logic [N_CL-1:0]    mask,
  input  logic [N_CL*IW-1:0] inc,
  output logic [N_CL*W-1:0]  offs,
  output logic [W-1:0]       total
);
  logic [W-1:0] pre [N_CL+1];

  assign pre[0] = '0;
  for (genvar k = 0; k < N_CL; k++) begin : g_chain
    assign pre[k+1] = pre[k] + (mask[k] ? W'(inc[k*IW +: IW]) : {W{1'b0}});
    assign offs[k*W +: W] = pre[k];
  end
  assign total = pre[N_CL];
endmodule

// File: rtl/psum_combiner.sv
module psum_combiner #(
  parameter int unsigned N_CL   = psum_pkg::PS_CLUSTERS,
  parameter int unsigned N_BASE = psum_pkg::PS_BASES,
  parameter int unsigned W      = psum_pkg::PS_WIDTH,
  parameter int unsigned IW     = psum_pkg::PS_INC_W,
  parameter int unsigned LANES  = psum_pkg::PS_LANES,
  localparam int unsigned BW    = (N_BASE > 1) ? $clog2(N_BASE) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_CL-1:0]          req_valid,
  input  logic [N_CL*BW-1:0]       req_base,
  input  logic [N_CL*IW-1:0]       req_inc,
  output logic [N_CL-1:0]          req_ready,
  output logic [LANES-1:0]         bc_valid,
  output logic [LANES*BW-1:0]      bc_base,
  output logic [LANES*W-1:0]       bc_old,
  output logic [LANES*N_CL-1:0]    bc_mask,
  output logic [LANES*N_CL*W-1:0]  bc_offs
);
  logic [LANES-1:0]      lane_v;
  logic [LANES*BW-1:0]   lane_base;
  logic [LANES*N_CL-1:0] lane_mask;

  psum_lane_sel #(.N_CL(N_CL), .BW(BW), .LANES(LANES)) u_sel (
    .req_valid (req_valid),
    .req_base  (req_base),
    .req_ready (req_ready),
    .lane_v    (lane_v),
    .lane_base (lane_base),
    .lane_mask (lane_mask)
  );

  // stage 1: batch formation registers
  logic [LANES-1:0]      s1_v;
  logic [LANES*BW-1:0]   s1_base;
  logic [LANES*N_CL-1:0] s1_mask;
  logic [N_CL*IW-1:0]    s1_inc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v    <= '0;
      s1_base <= '0;
      s1_mask <= '0;
      s1_inc  <= '0;
    end else begin
      s1_v    <= lane_v;
      s1_base <= lane_base;
      s1_mask <= lane_mask;
      s1_inc  <= req_inc;
    end
  end

  // stage 2: read-modify-write of the base file and broadcast
  logic [W-1:0]          base_q   [N_BASE];
  logic [W-1:0]          lane_old [LANES];
  logic [W-1:0]          lane_tot [LANES];
  logic [LANES*N_CL*W-1:0] lane_offs;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_old[l] = base_q[s1_base[l*BW +: BW]];
    psum_batch_exec #(.N_CL(N_CL), .W(W), .IW(IW)) u_exec (
      .mask  (s1_mask[l*N_CL +: N_CL]),
      .inc   (s1_inc),
      .offs  (lane_offs[l*N_CL*W +: N_CL*W]),
      .total (lane_tot[l])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_BASE; i++) base_q[i] <= '0;
      bc_valid <= '0;
      bc_base  <= '0;
      bc_old   <= '0;
      bc_mask  <= '0;
      bc_offs  <= '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (s1_v[l]) base_q[s1_base[l*BW +: BW]] <= lane_old[l] + lane_tot[l];
        bc_old[l*W +: W] <= lane_old[l];
      end
      bc_valid <= s1_v;
      bc_base  <= s1_base;
      bc_mask  <= s1_mask;
      bc_offs  <= lane_offs;
    end
  end

  // checker state: accepted / refused requests one edge ago
  logic acc_d, stall_d;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_d   <= 1'b0;
      stall_d <= 1'b0;
    end else begin
      acc_d   <= |(req_valid & req_ready);
      stall_d <= |(req_valid & ~req_ready);
    end
  end

  assert_accept_broadcast_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_d |=> (|bc_valid));
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_d |=> (bc_valid == '0));
  assert_refuse_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall_d |=> (&bc_valid));

  for (genvar a = 0; a < LANES; a++) begin : g_chk_a
    for (genvar c = a + 1; c < LANES; c++) begin : g_chk_c
      assert_distinct_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bc_valid[a] && bc_valid[c]) |-> (bc_base[a*BW +: BW] != bc_base[c*BW +: BW]));
      assert_disjoint_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bc_mask[a*N_CL +: N_CL] & bc_mask[c*N_CL +: N_CL]) == '0);
    end
  end
endmodule

// File: tb/psum_combiner_tb.sv
`timescale 1ns/1ps
module psum_combiner_tb_top;
  localparam int NC = 4, NB = 8, W = 16, IW = 8, NL = 2, BW = 3;
  localparam int MOD = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NC-1:0]      req_valid = '0;
  logic [NC*BW-1:0]   req_base = '0;
  logic [NC*IW-1:0]   req_inc = '0;
  logic [NC-1:0]      req_ready;
  logic [NL-1:0]      bc_valid;
  logic [NL*BW-1:0]   bc_base;
  logic [NL*W-1:0]    bc_old;
  logic [NL*NC-1:0]   bc_mask;
  logic [NL*NC*W-1:0] bc_offs;

  always #2 clk = ~clk;

  psum_combiner dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_base(req_base),
    .req_inc(req_inc), .req_ready(req_ready), .bc_valid(bc_valid),
    .bc_base(bc_base), .bc_old(bc_old), .bc_mask(bc_mask), .bc_offs(bc_offs));

  int nchk = 0, nfail = 0;
  bit done = 0;

  // pending requests per cluster, and the behavioural model state
  int want_v [NC], want_b [NC], want_i [NC];
  int base_m [NB];
  int e0_v [NL], e0_b [NL], e0_o [NL], e0_m [NL], e0_off [NL][NC];
  int e1_v [NL], e1_b [NL], e1_o [NL], e1_m [NL], e1_off [NL][NC];

  task automatic chk(string tag, int got, int exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s got %0d exp %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic tick();
    int nl;
    int lb [NL];
    int acc [NC];
    int lane_of [NC];
    @(negedge clk);
    // compare broadcast against what the model expected for this cycle
    for (int l = 0; l < NL; l++) begin
      chk("R2 lane valid", int'(bc_valid[l]), e0_v[l]);
      if (e0_v[l] != 0) begin
        chk("R6 lane base", int'(bc_base[l*BW +: BW]), e0_b[l]);
        chk("R3 lane mask", int'(bc_mask[l*NC +: NC]), e0_m[l]);
        chk("R5 old base", int'(bc_old[l*W +: W]), e0_o[l]);
        for (int k = 0; k < NC; k++)
          chk("R4 offset", int'(bc_offs[(l*NC+k)*W +: W]), e0_off[l][k]);
      end
    end
    for (int l = 0; l < NL; l++) begin
      e0_v[l] = e1_v[l]; e0_b[l] = e1_b[l]; e0_o[l] = e1_o[l]; e0_m[l] = e1_m[l];
      for (int k = 0; k < NC; k++) e0_off[l][k] = e1_off[l][k];
    end
    for (int i = 0; i < NC; i++) begin
      req_valid[i] = (want_v[i] != 0);
      req_base[i*BW +: BW] = want_b[i][BW-1:0];
      req_inc[i*IW +: IW] = want_i[i][IW-1:0];
    end
    #1;
    if (!rst_n) begin
      for (int l = 0; l < NL; l++) e1_v[l] = 0;
      return;
    end
    nl = 0;
    for (int i = 0; i < NC; i++) begin
      int g;
      g = -1;
      acc[i] = 0;
      if (want_v[i] != 0) begin
        for (int l = 0; l < nl; l++) if (lb[l] == want_b[i]) g = l;
        if (g < 0 && nl < NL) begin lb[nl] = want_b[i]; g = nl; nl++; end
      end
      chk("R7 ready", int'(req_ready[i]), (want_v[i] == 0 || g >= 0) ? 1 : 0);
      if (want_v[i] != 0 && g >= 0) begin acc[i] = 1; lane_of[i] = g; end
    end
    for (int l = 0; l < NL; l++) begin
      int run;
      e1_v[l] = (l < nl) ? 1 : 0;
      e1_m[l] = 0;
      if (l < nl) begin
        e1_b[l] = lb[l];
        e1_o[l] = base_m[lb[l]];
        run = 0;
        for (int k = 0; k < NC; k++) begin
          e1_off[l][k] = run % MOD;
          if (acc[k] != 0 && lane_of[k] == l) begin
            e1_m[l] = e1_m[l] | (1 << k);
            run = run + want_i[k];          // R10: unsigned increment
          end
        end
        base_m[lb[l]] = (e1_o[l] + run) % MOD;  // R9: modular wrap
      end
    end
    for (int i = 0; i < NC; i++) if (acc[i] != 0) want_v[i] = 0;
  endtask

  task automatic put(int c, int b, int inc);
    want_v[c] = 1; want_b[c] = b; want_i[c] = inc;
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    while ((want_v[0] | want_v[1] | want_v[2] | want_v[3]) != 0 && guard < 20) begin
      tick(); guard++;
    end
    tick(); tick(); tick();
  endtask

  initial begin
    for (int i = 0; i < NC; i++) begin want_v[i] = 0; want_b[i] = 0; want_i[i] = 0; end
    for (int i = 0; i < NB; i++) base_m[i] = 0;
    for (int l = 0; l < NL; l++) begin e0_v[l] = 0; e1_v[l] = 0; end
    repeat (3) tick();
    rst_n = 1'b1;
    tick(); tick();
    // R1: reset state
    chk("R1 no broadcast after reset", int'(bc_valid), 0);
    chk("R1 ready after reset", int'(req_ready), 15);

    // single request, old value 0 after reset (R1, R2)
    put(2, 3, 5); drain();
    // all four clusters on one base: one batch, ordered offsets (R3, R4)
    put(0, 1, 1); put(1, 1, 2); put(2, 1, 3); put(3, 1, 4); drain();
    // back-to-back batches on the same base (R5)
    put(0, 1, 7); put(3, 1, 9); tick();
    put(1, 1, 2); tick();
    put(2, 1, 6); drain();
    // three distinct bases: cluster 3 is refused once then served (R6, R7)
    put(0, 2, 3); put(1, 5, 4); put(2, 2, 8); put(3, 7, 1); drain();
    // lane order follows lowest requester index (R6)
    put(0, 6, 1); put(1, 0, 2); put(2, 0, 2); put(3, 6, 3); drain();
    // zero increment reads without advancing (R8)
    put(0, 4, 0); put(2, 4, 0); drain();
    put(1, 4, 3); put(3, 4, 0); drain();
    // wrap of base 6 with full-scale increments (R9, R10)
    for (int r = 0; r < 70; r++) begin
      put(0, 6, 255); put(1, 6, 255); put(2, 6, 255); put(3, 6, 255); tick();
    end
    drain();
    // random traffic with held requests
    for (int r = 0; r < 400; r++) begin
      for (int i = 0; i < NC; i++)
        if (want_v[i] == 0 && ($urandom % 3) != 0)
          put(i, int'($urandom % NB), int'($urandom % 256));
      tick();
    end
    drain();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    #(4 * 50000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end
endmodule